// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock waveform of an I2C bus master from the system clock. A programmable prescaler divides the system clock into a slower module time base. Two programmable phase counts set how many module-clock periods SCL stays low and how many it stays high. Each phase is lengthened by a small fixed offset whose value depends on the prescaler setting. The full SCL period is therefore (low count + offset) + (high count + offset) module clocks, where one module clock is (prescaler + 1) system cycles. The prescaler should be programmed so that the module clock falls roughly between 7 and 12 MHz.

The surrounding controller drives `run`. While `run` is low, SCL is released high, all counters are cleared, and the three settings are sampled on every cycle. Raising `run` freezes the settings and starts the waveform with a low phase. Dropping `run` returns SCL high on the next clock. One-cycle strobes mark each falling and each rising SCL edge, so a data shifter can align itself to the waveform.

Top module: `scl_pacer`

## Requirements
- R1: While `run` is low, `scl_o` is 1 and `fall_tick` and `rise_tick` are 0 from the next clock edge on.
- R2: On the first clock edge that samples `run` high after it was low, `scl_o` goes to 0 and `fall_tick` is 1 for that cycle.
- R3: The low phase lasts (CLKL + d) * (PSC + 1) system cycles, where CLKL is `low_cnt` and PSC is `div_pre`.
- R4: The high phase lasts (CLKH + d) * (PSC + 1) system cycles, where CLKH is `high_cnt`.
- R5: The offset d is 7 when `div_pre` is 0, 6 when it is 1, and 5 when it is 2 or more.
- R6: `fall_tick` is 1 for exactly the cycle in which `scl_o` has just become 0, and `rise_tick` is 1 for exactly the cycle in which `scl_o` has just become 1. The two are never 1 together.
- R7: The settings are captured on every clock edge on which `run` is low. Changes to `div_pre`, `low_cnt` or `high_cnt` while `run` is high have no effect until `run` has been low for at least one edge.
- R8: If `run` drops in the middle of a phase and then rises again, the waveform restarts with a full-length low phase.
- R9: While `rst_n` is low, `scl_o` is 1 and both ticks are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enable: 1 generates SCL, 0 releases SCL and reloads the settings |
| div_pre | input | W | Prescaler value PSC; module clock = clk / (PSC + 1) |
| low_cnt | input | W | Low-phase count CLKL in module clocks, before the offset |
| high_cnt | input | W | High-phase count CLKH in module clocks, before the offset |
| scl_o | output | 1 | SCL drive level (1 = released) |
| fall_tick | output | 1 | One-cycle strobe after each falling SCL edge |
| rise_tick | output | 1 | One-cycle strobe after each rising SCL edge |

## Verification
The assertions assume that `run` is a clean level, that the settings only change in a way the block tolerates, and that the phase limit is never below the smallest offset. The phase limit can only be at least 5, because the offset is always added. The bench changes the settings only while `run` is low and at least one cycle before raising it, except in the case that deliberately changes them mid-run to show that they are ignored. It uses small counts so that every phase length can be counted exactly, cycle by cycle, at the falling clock edge.

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int W    = 16,
  parameter int OFF0 = 7,
  parameter int OFF1 = 6,
  parameter int OFFN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div_pre,
  input  logic [W-1:0] low_cnt,
  input  logic [W-1:0] high_cnt,
  output logic         scl_o,
  output logic         fall_tick,
  output logic         rise_tick
);
  localparam int CW = W + 1;

  logic [W-1:0]  pre_s, lo_s, hi_s;
  logic [W-1:0]  pcnt;
  logic [CW-1:0] ph, lim, ofs;
  logic          act, mod_tick;

  assign ofs      = (pre_s == '0)          ? CW'(OFF0) :
                    (pre_s == W'(1))       ? CW'(OFF1) : CW'(OFFN);
  assign lim      = (scl_o ? {1'b0, hi_s} : {1'b0, lo_s}) + ofs;
  assign mod_tick = (pcnt == pre_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      scl_o     <= 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      pcnt      <= '0;
      ph        <= '0;
      pre_s     <= '0;
      lo_s      <= '0;
      hi_s      <= '0;
    end else if (!run) begin
      act       <= 1'b0;
      scl_o     <= 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      pcnt      <= '0;
      ph        <= '0;
      pre_s     <= div_pre;
      lo_s      <= low_cnt;
      hi_s      <= high_cnt;
    end else if (!act) begin
      act       <= 1'b1;
      scl_o     <= 1'b0;
      fall_tick <= 1'b1;
      rise_tick <= 1'b0;
      pcnt      <= '0;
      ph        <= '0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      pcnt      <= mod_tick ? '0 : pcnt + 1'b1;
      if (mod_tick) begin
        if (ph == lim - 1'b1) begin
          ph        <= '0;
          scl_o     <= ~scl_o;
          fall_tick <= scl_o;
          rise_tick <= ~scl_o;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  // R1: disabled means released and quiet
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !fall_tick && !rise_tick));

  // R2: start with a falling edge
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (!scl_o && fall_tick));

  // R6: ticks follow the edges
  a_r6_tick_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_tick && rise_tick));
  a_r6_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!scl_o && $past(scl_o)));
  a_r6_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl_o && !$past(scl_o)));
  a_r6_edge_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (scl_o != $past(scl_o))) |-> (fall_tick || rise_tick));

  // R3/R4: phase counter stays inside the phase limit
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ph < lim);

  // R7: settings frozen while running
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(pre_s) && $stable(lo_s) && $stable(hi_s)));
endmodule

// File: tb/test_scl_pacer.sv
module test_scl_pacer;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [W-1:0] div_pre = '0, low_cnt = '0, high_cnt = '0;
  logic scl_o, fall_tick, rise_tick;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scl_pacer #(.W(W)) i_scl_pacer (
    .clk(clk), .rst_n(rst_n), .run(run), .div_pre(div_pre),
    .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_o(scl_o), .fall_tick(fall_tick), .rise_tick(rise_tick));

  localparam logic [47:0] VEC [5] = '{
    {16'd0, 16'd3, 16'd4},
    {16'd1, 16'd2, 16'd5},
    {16'd2, 16'd0, 16'd1},
    {16'd4, 16'd6, 16'd2},
    {16'd0, 16'd0, 16'd0}
  };

  function automatic int offs(int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_regs(int p, int l, int h);
    div_pre = W'(p); low_cnt = W'(l); high_cnt = W'(h);
  endtask

  task automatic start_run;
    run = 1'b1;
    @(negedge clk);
    chk("R2 scl low after start", int'(scl_o), 0);
    chk("R2 fall tick at start", int'(fall_tick), 1);
  endtask

  task automatic measure(output int lo, output int hi);
    lo = 0;
    while (scl_o == 1'b0) begin lo++; @(negedge clk); end
    chk("R6 rise tick at rising edge", int'(rise_tick), 1);
    hi = 0;
    while (scl_o == 1'b1) begin hi++; @(negedge clk); end
    chk("R6 fall tick at falling edge", int'(fall_tick), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lo, hi;
    repeat (3) @(negedge clk);
    chk("R9 scl high in reset", int'(scl_o), 1);
    chk("R9 no ticks in reset", int'(fall_tick | rise_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      int p, l, h;
      p = int'(VEC[i][47:32]); l = int'(VEC[i][31:16]); h = int'(VEC[i][15:0]);
      set_regs(p, l, h);
      repeat (2) @(negedge clk);
      start_run();
      measure(lo, hi);
      chk("R3 R5 low length", lo, (l + offs(p)) * (p + 1));
      chk("R4 R5 high length", hi, (h + offs(p)) * (p + 1));
      measure(lo, hi);
      chk("R3 second low length", lo, (l + offs(p)) * (p + 1));
      run = 1'b0;
      @(negedge clk);
      chk("R1 scl released", int'(scl_o), 1);
      chk("R1 no ticks idle", int'(fall_tick | rise_tick), 0);
    end

    // R7: changes while running are ignored
    set_regs(0, 3, 4);
    repeat (2) @(negedge clk);
    start_run();
    set_regs(3, 20, 20);
    measure(lo, hi);
    chk("R7 low ignores live change", lo, 10);
    chk("R7 high ignores live change", hi, 11);
    run = 1'b0;
    repeat (2) @(negedge clk);
    start_run();
    measure(lo, hi);
    chk("R7 new low after reload", lo, 100);
    chk("R7 new high after reload", hi, 100);

    // R8: drop mid-phase, restart full length
    run = 1'b0;
    set_regs(1, 2, 2);
    repeat (2) @(negedge clk);
    start_run();
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R8 scl high after drop", int'(scl_o), 1);
    @(negedge clk);
    start_run();
    measure(lo, hi);
    chk("R8 full low after restart", lo, 16);
    chk("R8 full high after restart", hi, 16);
    run = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule